// File: doc/BRIEF.md
# Windowed Pulse Frequency Counter

This block counts the edges of a digital input during a measurement window whose length is a number of timebase ticks. A separate timebase supplies the ticks as a one-cycle enable. When a window closes, the block copies the edge total into a result register and raises a sticky done flag, which also drives the interrupt output. The input is meant for fast signals. It passes through a plain flop synchroniser with no glitch filter, so a pulse that lasts a single clock cycle is still counted.

A start strobe begins a window and captures the mode and the edge polarity. In single-shot mode the block measures one window and then goes idle. In continuous mode a new window begins in the same cycle the old one closes, with no gap. Each edge goes into exactly one window, including an edge that falls on the closing cycle. The counter saturates at its maximum value, and the result then carries an overflow bit.

Top module: `pulse_rate_meter`

## Requirements
- R1: When `cfgEdgeFall`=0 is captured at start, only low-to-high transitions of `sigIn` are counted. When it is 1, only high-to-low transitions are counted.
- R2: A window lasts exactly `cfgWinLen` cycles in which `tickEn` is high, counted after the start cycle. The tick that ends the window sets `doneFlag` at that clock edge. Cycles with `tickEn` low do not advance the window, and a tick in the start cycle is ignored.
- R3: A `cfgWinLen` of 0 gives a window of one tick.
- R4: In single-shot mode (`cfgContinuous`=0) the block goes idle after one window. Later input edges leave `resultCount` unchanged and do not set `doneFlag` again.
- R5: In continuous mode (`cfgContinuous`=1) the next window starts with a zero count right after each window ends. An edge detected in the closing cycle belongs to the closing window, so any run of consecutive windows accounts for every edge exactly once.
- R6: At each window end, `resultCount` and `resultOvf` are updated and `doneFlag` is set. `doneFlag` stays high until `clearDone` is pulsed. If a window ends in the same cycle as `clearDone`, the flag is set. `irq` follows `doneFlag`.
- R7: The counter stops at 2^CNT_W-1. If further edges arrive in that window, `resultOvf` reads 1 for it. The next window starts with the overflow bit cleared.
- R8: A start strobe, even during a running window, discards the current count and begins a fresh window. Edges seen before the start are not counted.
- R9: Pulses one clock cycle wide, separated by one low cycle, are each counted (no filtering).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timebase tick enable, one cycle per tick |
| sigIn | input | 1 | Asynchronous signal whose edges are counted |
| cfgWinLen | input | WIN_W | Window length in ticks (0 means 1) |
| cfgEdgeFall | input | 1 | 0 counts rising edges, 1 counts falling edges |
| cfgContinuous | input | 1 | 0 single-shot, 1 back-to-back windows |
| startReq | input | 1 | One-cycle strobe that starts a window |
| clearDone | input | 1 | One-cycle strobe that clears the done flag |
| busy | output | 1 | A window is running |
| doneFlag | output | 1 | Sticky window-complete flag |
| irq | output | 1 | Interrupt request, equal to the done flag |
| resultCount | output | CNT_W | Edge count of the last finished window |
| resultOvf | output | 1 | Last finished window saturated |

## Verification
Single-shot windows are driven with square pulse trains of 0 to 12 pulses under both polarities, so an off-by-one or a swapped polarity shows up as a wrong total. A lone rise and a lone fall are also applied, and each must be seen by one polarity setting and missed by the other. Window length is swept from 0 to 6 using sparse, hand-placed ticks, which separates tick counting from cycle counting. Continuous mode runs a square wave whose period does not divide the window length, so a lost or double-counted edge at a boundary changes the sum of four windows. Further patterns cover one-cycle pulses driven into saturation, a restart in the middle of a window, and edges after a single-shot window has ended.

// File: rtl/prm_pkg.sv
package prm_pkg;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic loadCfg;   // capture per-window configuration
    logic clrCnt;    // zero the running count (start)
    logic cntEn;     // a window is open this cycle
    logic latchRes;  // window closes this cycle
    logic restart;   // a new window follows at once
  } prm_strobe_t;

endpackage

// File: rtl/prm_ctrl.sv
module prm_ctrl
  import prm_pkg::*;
#(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             startReq,
  input  logic             clearDone,
  input  logic [WIN_W-1:0] cfgWinLen,
  input  logic             cfgContinuous,
  output prm_strobe_t      strb,
  output logic             busy,
  output logic             doneFlag
);

  localparam logic [WIN_W-1:0] ONE_TICK = WIN_W'(1);

  logic [WIN_W-1:0] ticksLeft;
  logic [WIN_W-1:0] loadLen;
  logic             contQ;
  logic             lastTick;
  logic             winEnd;

  assign loadLen  = (cfgWinLen == '0) ? ONE_TICK : cfgWinLen;
  assign lastTick = (ticksLeft == ONE_TICK);
  assign winEnd   = busy && tickEn && lastTick && !startReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      ticksLeft <= ONE_TICK;
      contQ     <= 1'b0;
    end else if (startReq) begin
      busy      <= 1'b1;
      ticksLeft <= loadLen;
      contQ     <= cfgContinuous;
    end else if (busy && tickEn) begin
      if (lastTick) begin
        if (contQ) ticksLeft <= loadLen;
        else       busy      <= 1'b0;
      end else begin
        ticksLeft <= ticksLeft - ONE_TICK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          doneFlag <= 1'b0;
    else if (winEnd)    doneFlag <= 1'b1;
    else if (clearDone) doneFlag <= 1'b0;
  end

  always_comb begin
    strb.loadCfg  = startReq;
    strb.clrCnt   = startReq;
    strb.cntEn    = busy && !startReq;
    strb.latchRes = winEnd;
    strb.restart  = winEnd && contQ;
  end

  // R3: the tick counter never holds zero while a window runs
  p_ticks_nonzero_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ticksLeft != '0);

  // R4: single-shot goes idle after its window
  p_single_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latchRes && !contQ) |=> !busy);

  // R5: continuous mode keeps running across the boundary
  p_cont_run_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latchRes && contQ) |=> busy);

  // R6: a window end always leaves the flag set, even against a clear
  p_done_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchRes |=> doneFlag);

  // R6: the flag is sticky until the host clears it
  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !clearDone) |=> doneFlag);

endmodule

// File: rtl/prm_datapath.sv
module prm_datapath
  import prm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sigIn,
  input  logic             cfgEdgeFall,
  input  prm_strobe_t      strb,
  output logic [CNT_W-1:0] resultCount,
  output logic             resultOvf
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   curLvl;
  logic                   prevLvl;
  logic                   edgeFallQ;
  logic                   hit;
  logic [CNT_W-1:0]       cnt;
  logic                   ovfRun;
  logic                   atMax;
  logic [CNT_W-1:0]       nextCnt;
  logic                   nextOvf;

  // Synchroniser chain; depth chosen by parameter.
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sigIn};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= sigIn;
      end
    end
  endgenerate

  assign curLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLvl   <= 1'b0;
      edgeFallQ <= 1'b0;
    end else begin
      prevLvl <= curLvl;
      if (strb.loadCfg) edgeFallQ <= cfgEdgeFall;
    end
  end

  assign hit     = edgeFallQ ? (prevLvl && !curLvl) : (!prevLvl && curLvl);
  assign atMax   = (cnt == CNT_MAX);
  assign nextCnt = (hit && !atMax) ? cnt + CNT_ONE : cnt;
  assign nextOvf = ovfRun || (hit && atMax);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      ovfRun <= 1'b0;
    end else if (strb.clrCnt || strb.restart) begin
      cnt    <= '0;
      ovfRun <= 1'b0;
    end else if (strb.cntEn) begin
      cnt    <= nextCnt;
      ovfRun <= nextOvf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultCount <= '0;
      resultOvf   <= 1'b0;
    end else if (strb.latchRes) begin
      resultCount <= nextCnt;
      resultOvf   <= nextOvf;
    end
  end

  // R7: a saturated count stays at the ceiling within a window
  p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
    (atMax && strb.cntEn && !strb.restart) |=> cnt == CNT_MAX);

  // R7: an overflowed result always reads the ceiling
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    resultOvf |-> resultCount == CNT_MAX);

  // R5: the count advances by at most one per cycle inside a window
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntEn && !strb.restart) |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_ONE));

  // R5: the following window begins from zero
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (cnt == '0 && !ovfRun));

endmodule

// File: rtl/pulse_rate_meter.sv
module pulse_rate_meter
  import prm_pkg::*;
#(
  parameter int WIN_W       = 16,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             sigIn,
  input  logic [WIN_W-1:0] cfgWinLen,
  input  logic             cfgEdgeFall,
  input  logic             cfgContinuous,
  input  logic             startReq,
  input  logic             clearDone,
  output logic             busy,
  output logic             doneFlag,
  output logic             irq,
  output logic [CNT_W-1:0] resultCount,
  output logic             resultOvf
);

  prm_strobe_t strb;

  prm_ctrl #(.WIN_W(WIN_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .tickEn       (tickEn),
    .startReq     (startReq),
    .clearDone    (clearDone),
    .cfgWinLen    (cfgWinLen),
    .cfgContinuous(cfgContinuous),
    .strb         (strb),
    .busy         (busy),
    .doneFlag     (doneFlag)
  );

  prm_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sigIn      (sigIn),
    .cfgEdgeFall(cfgEdgeFall),
    .strb       (strb),
    .resultCount(resultCount),
    .resultOvf  (resultOvf)
  );

  assign irq = doneFlag;

endmodule

// File: tb/sim_pulse_rate_meter.sv
module sim_pulse_rate_meter;

  localparam int WIN_W = 16;
  localparam int CNT_W = 5;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             tickEn = 1'b0;
  logic             sigIn = 1'b0;
  logic [WIN_W-1:0] cfgWinLen = '0;
  logic             cfgEdgeFall = 1'b0;
  logic             cfgContinuous = 1'b0;
  logic             startReq = 1'b0;
  logic             clearDone = 1'b0;
  logic             busy, doneFlag, irq, resultOvf;
  logic [CNT_W-1:0] resultCount;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles++;

  pulse_rate_meter #(.WIN_W(WIN_W), .CNT_W(CNT_W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sigIn(sigIn),
    .cfgWinLen(cfgWinLen), .cfgEdgeFall(cfgEdgeFall), .cfgContinuous(cfgContinuous),
    .startReq(startReq), .clearDone(clearDone), .busy(busy), .doneFlag(doneFlag),
    .irq(irq), .resultCount(resultCount), .resultOvf(resultOvf)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic startWin(input int len, input logic fall, input logic cont);
    @(negedge clk);
    cfgWinLen = WIN_W'(len);
    cfgEdgeFall = fall;
    cfgContinuous = cont;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic clearPulse();
    @(negedge clk);
    clearDone = 1'b1;
    @(negedge clk);
    clearDone = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 2000; i++) begin
      if (doneFlag) break;
      @(negedge clk);
    end
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      sigIn = 1'b1; step(hi);
      sigIn = 1'b0; step(lo);
    end
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int winRes[8];
    int nWin;
    int sum;
    int seen;
    int held;
    step(3);
    // reset state
    check("R6 reset done", int'(doneFlag), 0);
    check("R6 reset irq", int'(irq), 0);
    check("R4 reset busy", int'(busy), 0);
    check("R6 reset result", int'(resultCount), 0);
    rstN = 1'b1;
    step(2);

    // R2 / R3: window length in ticks, with sparse ticks
    for (int len = 0; len <= 6; len++) begin
      int eff;
      eff = (len == 0) ? 1 : len;
      clearPulse();
      startWin(len, 1'b0, 1'b0);
      step(2);
      for (int k = 1; k <= eff; k++) begin
        tickEn = 1'b1;
        @(negedge clk);
        tickEn = 1'b0;
        if (k < eff) check(len == 0 ? "R3 early done" : "R2 early done", int'(doneFlag), 0);
        else         check(len == 0 ? "R3 done at tick" : "R2 done at tick", int'(doneFlag), 1);
        step(2);
      end
    end

    // R1: pulse count sweep under both polarities, single-shot
    tickEn = 1'b1;
    for (int pol = 0; pol < 2; pol++) begin
      for (int n = 0; n <= 12; n++) begin
        clearPulse();
        startWin(200, pol[0], 1'b0);
        step(4);
        pulses(n, 2, 2);
        waitDone();
        check(pol == 0 ? "R1 rising count" : "R1 falling count", int'(resultCount), n);
        check("R7 no ovf", int'(resultOvf), 0);
      end
    end

    // R1: lone transitions tell the polarities apart
    for (int pol = 0; pol < 2; pol++) begin
      sigIn = 1'b1; step(10);
      clearPulse();
      startWin(60, pol[0], 1'b0);
      step(5);
      sigIn = 1'b0;
      waitDone();
      check("R1 lone fall", int'(resultCount), pol);
      clearPulse();
      startWin(60, pol[0], 1'b0);
      step(5);
      sigIn = 1'b1;
      waitDone();
      check("R1 lone rise", int'(resultCount), 1 - pol);
      sigIn = 1'b0; step(10);
    end

    // R9 / R7: one-cycle pulses into saturation, then recovery
    clearPulse();
    startWin(200, 1'b0, 1'b0);
    step(4);
    pulses(20, 1, 1);
    waitDone();
    check("R9 narrow pulses", int'(resultCount), 20);
    clearPulse();
    startWin(200, 1'b0, 1'b0);
    step(4);
    pulses(CMAX + 9, 1, 1);
    waitDone();
    check("R7 saturated count", int'(resultCount), CMAX);
    check("R7 ovf set", int'(resultOvf), 1);
    clearPulse();
    startWin(200, 1'b0, 1'b0);
    step(4);
    pulses(3, 1, 1);
    waitDone();
    check("R7 ovf cleared next window", int'(resultOvf), 0);
    check("R7 count after ovf", int'(resultCount), 3);

    // R6: sticky flag, R4: idle after single shot
    step(30);
    check("R6 done sticky", int'(doneFlag), 1);
    check("R6 irq follows", int'(irq), 1);
    check("R4 idle", int'(busy), 0);
    clearPulse();
    check("R6 done cleared", int'(doneFlag), 0);
    pulses(5, 2, 2);
    step(250);
    check("R4 no new done", int'(doneFlag), 0);
    check("R4 result kept", int'(resultCount), 3);

    // R8: restart mid-window discards the count
    startWin(200, 1'b0, 1'b0);
    step(4);
    pulses(5, 2, 2);
    startWin(200, 1'b0, 1'b0);
    step(4);
    pulses(2, 2, 2);
    waitDone();
    check("R8 restart count", int'(resultCount), 2);

    // R5: continuous, square wave period 4 against window of 7
    clearPulse();
    sigIn = 1'b0;
    startWin(7, 1'b0, 1'b1);
    nWin = 0;
    for (int i = 0; i < 70; i++) begin
      if (i % 2 == 0) sigIn = ~sigIn;
      if (doneFlag && !clearDone) begin
        if (nWin < 8) winRes[nWin] = int'(resultCount);
        nWin++;
        clearDone = 1'b1;
      end else begin
        clearDone = 1'b0;
      end
      @(negedge clk);
    end
    clearDone = 1'b0;
    check("R5 window count", (nWin >= 6) ? 1 : 0, 1);
    sum = 0;
    for (int w = 2; w < 6; w++) begin
      sum += winRes[w];
      check("R5 per-window range", (winRes[w] == 1 || winRes[w] == 2) ? 1 : 0, 1);
    end
    check("R5 no lost edge over four windows", sum, 7);
    check("R5 still running", int'(busy), 1);

    // R6: set wins against a held clear
    startWin(3, 1'b0, 1'b1);
    clearDone = 1'b1;
    seen = 0;
    held = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (doneFlag) seen++;
      else held++;
    end
    clearDone = 1'b0;
    check("R6 set beats clear", (seen > 0) ? 1 : 0, 1);
    check("R6 clear acts between ends", (held > 0) ? 1 : 0, 1);
    startWin(1, 1'b0, 1'b0);
    waitDone();
    step(2);
    check("R4 stopped after single", int'(busy), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule